// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a master-side sequencer for a two-wire serial memory bus. Once a write command has been closed with a stop condition, the memory runs an internally timed write cycle. During that cycle it refuses to acknowledge its own address. The poller turns that refusal into a busy indication. On a trigger it opens an attempt with a start condition and then sends the control byte with the read/write bit cleared. It then looks at the acknowledge result.

If the acknowledge is missing, the poller closes the attempt with a stop condition and tries again straight away. No fixed delay is inserted. When an acknowledge arrives, the poller reports completion and leaves the bus held after the acknowledged byte, so the caller can continue with its next read or write. A programmable attempt limit ends a fruitless loop with a timeout indication.

The poller does not drive the pads and does not generate bit timing. Those jobs belong to a bit-level bus engine. The poller talks to that engine through a command strobe with an operation code and a byte, and receives back a response strobe that carries the acknowledge result.

Top module: `ackPoller`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `cmdValid` are all low.
- R2: A `trigger` pulse seen while idle starts an attempt. The first command is a start (`cmdOp` = 0), and the second is a byte send (`cmdOp` = 1).
- R3: The byte sent is `{devType[3:0], chipSel[2:0], 1'b0}`. Bit 7 is the first bit on the wire, and bit 0 is the read/write bit, which is always 0. `devType` and `chipSel` are captured at the trigger.
- R4: A byte response with `rspAck` = 0 (not acknowledged) is followed by a stop command (`cmdOp` = 2). If the limit has not been reached, a new start follows once the stop has completed.
- R5: A byte response with `rspAck` = 1 makes `done` high for exactly one clock, in the cycle after that response. No stop is issued for that attempt.
- R6: `busy` is high from the cycle after the accepted trigger up to and including the cycle of the final response. It is low in the cycle where `done` or `timeout` is high. No command is issued while `busy` is low.
- R7: With a nonzero `maxAttempts` (captured at the trigger), the stop that closes the `maxAttempts`-th refused attempt ends the sequence. `timeout` is then high for one clock, in the cycle after that stop's response.
- R8: When `maxAttempts` is 0, attempts repeat without limit until an acknowledge is received.
- R9: `trigger` pulses and changes on `devType`, `chipSel` or `maxAttempts` while `busy` is high have no effect on the command sequence or on the outcome.
- R10: Each command strobe lasts one clock. No new command is issued until `rspValid` has returned for the previous one. `rspValid` seen while no command is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Start polling (honoured only when idle) |
| devType | input | 4 | Device type code for the control byte |
| chipSel | input | 3 | Chip-select bits for the control byte |
| maxAttempts | input | CNT_W | Attempt limit, 0 = unlimited |
| cmdValid | output | 1 | One-cycle command strobe to the bus engine |
| cmdOp | output | 2 | 0 start, 1 send byte, 2 stop |
| cmdByte | output | 8 | Byte to send when `cmdOp` = 1 |
| rspValid | input | 1 | Engine finished the outstanding command |
| rspAck | input | 1 | Acknowledge result of a byte send (1 = acknowledged) |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse: device acknowledged |
| timeout | output | 1 | One-cycle pulse: attempt limit exhausted |

## Verification
The polling loop is run with the device refusing a chosen number of attempts before it accepts: none, a few, exactly one fewer than the limit, exactly the limit, and more than the limit. This separates an acknowledge on the first try from one after retries, and a success on the last allowed attempt from a timeout. A run with a limit of 0 and several refusals shows whether the limit is truly disabled. Engine latencies of one and three cycles show whether the poller waits for each response rather than assuming a fixed delay. A run that pulses the trigger and changes the configuration in mid-sequence shows whether those inputs are captured only at the start.

// File: rtl/pollPkg.sv
package pollPkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } busOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic bumpCount;
    logic finishOk;
    logic finishErr;
  } pollStrobeT;
endpackage

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigger,
  input  logic       rspValid,
  input  logic       rspAck,
  input  logic       limitHit,
  output pollStrobeT strb,
  output logic       cmdValid,
  output busOpE      cmdOp,
  output logic       busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_SEND_START, S_WAIT_START, S_SEND_BYTE,
    S_WAIT_BYTE, S_SEND_STOP, S_WAIT_STOP
  } stateE;

  stateE state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    cmdValid  = 1'b0;
    cmdOp     = OP_START;
    case (state)
      S_IDLE: if (trigger) begin
        strb.latchCfg = 1'b1;
        nextState     = S_SEND_START;
      end
      S_SEND_START: begin
        cmdValid  = 1'b1;
        cmdOp     = OP_START;
        nextState = S_WAIT_START;
      end
      S_WAIT_START: if (rspValid) nextState = S_SEND_BYTE;
      S_SEND_BYTE: begin
        cmdValid  = 1'b1;
        cmdOp     = OP_BYTE;
        nextState = S_WAIT_BYTE;
      end
      S_WAIT_BYTE: if (rspValid) begin
        if (rspAck) begin
          strb.finishOk = 1'b1;
          nextState     = S_IDLE;
        end else begin
          strb.bumpCount = 1'b1;
          nextState      = S_SEND_STOP;
        end
      end
      S_SEND_STOP: begin
        cmdValid  = 1'b1;
        cmdOp     = OP_STOP;
        nextState = S_WAIT_STOP;
      end
      S_WAIT_STOP: if (rspValid) begin
        if (limitHit) begin
          strb.finishErr = 1'b1;
          nextState      = S_IDLE;
        end else begin
          nextState = S_SEND_START;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/pollData.sv
module pollData
  import pollPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pollStrobeT       strb,
  input  logic [3:0]       devType,
  input  logic [2:0]       chipSel,
  input  logic [CNT_W-1:0] maxAttempts,
  output logic [7:0]       cmdByte,
  output logic             limitHit,
  output logic             done,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [6:0]       addrReg;
  logic [CNT_W-1:0] limitReg;
  logic [CNT_W-1:0] tries;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      limitReg <= '0;
      tries    <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done    <= strb.finishOk;
      timeout <= strb.finishErr;
      if (strb.latchCfg) begin
        addrReg  <= {devType, chipSel};
        limitReg <= maxAttempts;
        tries    <= '0;
      end else if (strb.bumpCount && tries != CNT_MAX) begin
        tries <= tries + 1'b1;
      end
    end
  end

  assign cmdByte  = {addrReg, 1'b0};
  assign limitHit = (limitReg != '0) && (tries >= limitReg);
endmodule

// File: rtl/ackPoller.sv
module ackPoller
  import pollPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigger,
  input  logic [3:0]       devType,
  input  logic [2:0]       chipSel,
  input  logic [CNT_W-1:0] maxAttempts,
  output logic             cmdValid,
  output logic [1:0]       cmdOp,
  output logic [7:0]       cmdByte,
  input  logic             rspValid,
  input  logic             rspAck,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  pollStrobeT strb;
  logic       limitHit;
  busOpE      opSel;

  pollCtrl uCtrl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .rspValid(rspValid),
    .rspAck(rspAck), .limitHit(limitHit), .strb(strb),
    .cmdValid(cmdValid), .cmdOp(opSel), .busy(busy)
  );

  pollData #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .devType(devType),
    .chipSel(chipSel), .maxAttempts(maxAttempts), .cmdByte(cmdByte),
    .limitHit(limitHit), .done(done), .timeout(timeout)
  );

  assign cmdOp = opSel;
endmodule

// File: rtl/ackPollerChk.sv
module ackPollerChk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [7:0] cmdByte,
  input logic       rspValid,
  input logic       rspAck,
  input logic       busy,
  input logic       done,
  input logic       timeout
);
  // R5
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(rspValid && rspAck));

  // R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  // R10
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || timeout));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid);

  // R3
  rw_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |-> !cmdByte[0]);
endmodule

bind ackPoller ackPollerChk uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdByte(cmdByte), .rspValid(rspValid), .rspAck(rspAck),
  .busy(busy), .done(done), .timeout(timeout)
);

// File: tb/tb_ackPoller.sv
module tb_ackPoller;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0;
  logic [3:0] devType = 4'h0;
  logic [2:0] chipSel = 3'h0;
  logic [CNT_W-1:0] maxAttempts = '0;
  logic rspValid = 1'b0;
  logic rspAck = 1'b0;
  logic cmdValid, busy, done, timeout;
  logic [1:0] cmdOp;
  logic [7:0] cmdByte;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ackPoller #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .trigger(trigger), .devType(devType),
    .chipSel(chipSel), .maxAttempts(maxAttempts), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdByte(cmdByte), .rspValid(rspValid), .rspAck(rspAck),
    .busy(busy), .done(done), .timeout(timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Polls with the device refusing `nacks` attempts, then accepting.
  task automatic runPoll(input int nacks, input int limit, input int lat,
                         input logic [3:0] dt, input logic [2:0] cs,
                         input bit poke);
    int expQ[$];
    int rounds, byteIdx, stopIdx, cnt, cyc, expOp;
    bit toCase, busyM, finalPrev, finalOk, pendAck, pendFinal, ended;
    logic [7:0] expByte;
    expByte = {dt, cs, 1'b0};
    toCase  = (limit != 0) && (nacks >= limit);
    rounds  = toCase ? limit : nacks;
    for (int i = 0; i < rounds; i++) begin
      expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    end
    if (!toCase) begin
      expQ.push_back(0); expQ.push_back(1);
    end
    byteIdx = 0; stopIdx = 0; cnt = 0; cyc = 0;
    busyM = 0; finalPrev = 0; finalOk = 0; ended = 0;
    pendAck = 0; pendFinal = 0;
    while (!ended) begin
      @(negedge clk);
      // R5 R7 outcome pulses follow the final response by one cycle
      check(toCase ? "R7 timeout" : "R5 done", toCase ? int'(timeout) : int'(done),
            (finalPrev && (toCase ? !finalOk : finalOk)) ? 1 : 0);
      check(toCase ? "R7 no done" : "R5 no timeout", toCase ? int'(done) : int'(timeout), 0);
      if (finalPrev) begin
        busyM = 0;
        ended = 1;
      end
      finalPrev = 0;
      // R6
      check("R6 busy", int'(busy), int'(busyM));
      // engine model
      rspValid = 1'b0;
      rspAck   = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rspValid  = 1'b1;
          rspAck    = pendAck;
          finalPrev = pendFinal;
          finalOk   = pendAck;
        end
      end
      if (cmdValid) begin
        // R10 no command while one is outstanding
        check("R10 single outstanding", (cnt > 0 || rspValid) ? 1 : 0, 0);
        expOp = (expQ.size() > 0) ? expQ.pop_front() : -1;
        // R2 R4 sequence of operations
        check("R2/R4 op", int'(cmdOp), expOp);
        pendAck = 0; pendFinal = 0;
        if (cmdOp == 2'd1) begin
          // R3 control byte
          check("R3 byte", int'(cmdByte), int'(expByte));
          pendAck   = (byteIdx >= nacks);
          pendFinal = pendAck;
          byteIdx++;
        end else if (cmdOp == 2'd2) begin
          stopIdx++;
          pendFinal = toCase && (stopIdx == limit);
        end
        cnt = lat;
      end
      // stimulus for the next edge
      trigger = 1'b0;
      if (cyc == 0) begin
        devType = dt; chipSel = cs; maxAttempts = CNT_W'(limit);
        trigger = 1'b1;
        busyM   = 1;
      end else if (poke && (cyc % 3 == 1)) begin
        // R9 disturbances while busy
        trigger = 1'b1;
        devType = ~dt; chipSel = ~cs; maxAttempts = CNT_W'(1);
      end
      cyc++;
    end
    // R2 every expected command consumed
    check("R2 sequence complete", expQ.size(), 0);
    rspValid = 1'b0;
    trigger  = 1'b0;
    // idle with a stray response: R10 ignored, R6 quiet
    @(negedge clk);
    rspValid = 1'b1; rspAck = 1'b1;
    @(negedge clk);
    rspValid = 1'b0; rspAck = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R10 stray rsp ignored", int'(cmdValid) + int'(busy) + int'(done), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 timeout", int'(timeout), 0);
    check("R1 cmdValid", int'(cmdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    runPoll(0, 4, 1, 4'hA, 3'd0, 0);   // R5 first-try acknowledge
    runPoll(3, 8, 2, 4'hA, 3'd5, 0);   // R4 retries then acknowledge
    runPoll(10, 3, 1, 4'h5, 3'd2, 0);  // R7 limit exceeded
    runPoll(2, 2, 3, 4'hC, 3'd7, 0);   // R7 boundary: refusals equal limit
    runPoll(1, 2, 1, 4'h3, 3'd1, 0);   // R7 boundary: ack on last try
    runPoll(6, 0, 3, 4'hF, 3'd6, 0);   // R8 unlimited
    runPoll(2, 5, 2, 4'h9, 3'd3, 1);   // R9 mid-sequence disturbances
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule